// File: doc/BRIEF.md
# Vertical Countdown with Trigger Window

This block derives vertical field timing from a pulse that arrives twice per scan line. It counts half-lines since the last vertical reset. It accepts a separated vertical trigger only while that count is inside a window that depends on the field rate. It also issues a vertical reset, a one-line level-control sample pulse for the ramp generator, and three status flags: trigger present, 50 Hz selected, and standard signal selected.

A second counter measures the half-lines between consecutive raw triggers. That measurement drives two decisions:
- The automatic 50/60 Hz decision.
- The automatic decision between standard and non-standard signals.

In non-standard operation every accepted trigger restarts the field. When no trigger is accepted, the field ends by itself at the close of the window. In standard operation the field is ended by the block's own divider at the nominal field length, and triggers no longer restart it. A 3-bit mode input can force either decision.

Top module: `vert_countdown`

## Requirements
- R1: After reset, vreset, alc_pulse, vdet, is_50hz and is_std are all 0. The automatic rate decision starts at 60 Hz.
- R2: At 60 Hz in non-standard operation, a trigger resets the field only when the half-line count since the last reset lies in 450..594 (lines 225..297). Such a trigger sets vdet to 1. Triggers outside that range change nothing.
- R3: At 50 Hz in non-standard operation, the acceptance range is 576..714 half-lines (lines 288..357).
- R4: In non-standard operation, if no trigger is accepted, the field resets on the first half-line tick after the count reaches the window end (594 or 714), and vdet goes to 0.
- R5: In standard operation the field resets on the half-line tick that completes 525 (60 Hz) or 625 (50 Hz) half-lines. Triggers do not reset the field, although an in-window trigger still sets vdet.
- R6: mode_sel[2] = 1 forces non-standard operation: is_std reads 0 and triggers reset the field. mode_sel[2] = 0 leaves the automatic decision in effect.
- R7: mode_sel[1:0] selects the rate: 01 forces 50 Hz, 10 forces 60 Hz, and 00 or 11 use the automatic decision.
- R8: Automatic standard detection sets is_std after 8 consecutive trigger intervals within ±1 half-line of the nominal length. A bad interval clears it at once. Reaching nominal+2 half-lines without a trigger also clears it at once.
- R9: The automatic rate decision changes only after 4 consecutive trigger intervals that lie in the other rate's window and not in the current rate's window. Any other interval restarts the vote.
- R10: alc_pulse is high for exactly two half-lines, from count 449 (60 Hz) or count 536 (50 Hz) after the last reset.
- R11: Each field reset produces exactly one clock cycle of vreset, in the clock cycle after the reset event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hl_tick | input | 1 | One-clock pulse, twice per scan line |
| vtrig | input | 1 | One-clock separated vertical trigger |
| mode_sel | input | 3 | [2] force non-standard, [1:0] rate select |
| vreset | output | 1 | One-clock vertical reset pulse |
| alc_pulse | output | 1 | One-line ramp level-control sample window |
| vdet | output | 1 | Vertical trigger being detected |
| is_50hz | output | 1 | Current rate decision (1 = 50 Hz) |
| is_std | output | 1 | Current standard decision (1 = standard) |

## Verification
Triggers are placed one half-line either side of each window edge at both field rates. This separates an inclusive range from an off-by-one range, and it shows the free-running reset when no trigger comes. A run of nominal-length intervals shows the standard decision taking hold on exactly the eighth interval. It then shows the divider, rather than the trigger, ending the field, and a missing trigger dropping the decision one half-line past tolerance. Intervals of 625 and 525 half-lines, including a broken run, separate a true four-field vote from one that counts non-consecutive fields. The forced mode values are compared against the automatic decision they override.

// File: rtl/vcd_pkg.sv
package vcd_pkg;

    typedef enum logic [1:0] {
        RATE_AUTO_A = 2'b00,
        RATE_F50    = 2'b01,
        RATE_F60    = 2'b10,
        RATE_AUTO_B = 2'b11
    } rate_sel_e;

    // Effective field rate from the selector and the automatic decision.
    function automatic logic pick_50(input logic [1:0] sel, input logic auto50);
        case (rate_sel_e'(sel))
            RATE_F50: return 1'b1;
            RATE_F60: return 1'b0;
            default:  return auto50;
        endcase
    endfunction

endpackage

// File: rtl/vcd_interval.sv
module vcd_interval #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hl_tick,
    input  logic             vtrig,
    output logic [CNT_W-1:0] gap
);
    localparam logic [CNT_W-1:0] SAT = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ival_t;

    ival_t ival_d, ival_q;

    always_comb begin
        ival_d = ival_q;
        if (vtrig) begin
            ival_d.cnt = '0;
        end else if (hl_tick && ival_q.cnt != SAT) begin
            ival_d.cnt = ival_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ival_q.cnt <= SAT;
        end else begin
            ival_q <= ival_d;
        end
    end

    assign gap = ival_q.cnt;

endmodule

// File: rtl/vcd_rate_sel.sv
module vcd_rate_sel
    import vcd_pkg::*;
#(
    parameter int CNT_W  = 10,
    parameter int W60_LO = 450,
    parameter int W60_HI = 594,
    parameter int W50_LO = 576,
    parameter int W50_HI = 714,
    parameter int VOTES  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vtrig,
    input  logic [CNT_W-1:0] gap,
    input  logic [1:0]       rate_sel,
    output logic             is50,
    output logic             flip
);
    localparam int VW = $clog2(VOTES + 1);
    localparam logic [VW-1:0]    VLAST = VW'(VOTES - 1);
    localparam logic [CNT_W-1:0] LO60  = CNT_W'(W60_LO);
    localparam logic [CNT_W-1:0] HI60  = CNT_W'(W60_HI);
    localparam logic [CNT_W-1:0] LO50  = CNT_W'(W50_LO);
    localparam logic [CNT_W-1:0] HI50  = CNT_W'(W50_HI);

    typedef struct packed {
        logic          auto50;
        logic [VW-1:0] votes;
    } rate_t;

    rate_t rate_d, rate_q;
    logic  in60, in50, other;

    always_comb begin
        in60   = (gap >= LO60) && (gap <= HI60);
        in50   = (gap >= LO50) && (gap <= HI50);
        other  = rate_q.auto50 ? (in60 && !in50) : (in50 && !in60);
        rate_d = rate_q;
        flip   = 1'b0;
        if (vtrig) begin
            if (!other) begin
                rate_d.votes = '0;
            end else if (rate_q.votes == VLAST) begin
                rate_d.auto50 = !rate_q.auto50;
                rate_d.votes  = '0;
                flip          = 1'b1;
            end else begin
                rate_d.votes = rate_q.votes + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_q <= '0;
        end else begin
            rate_q <= rate_d;
        end
    end

    assign is50 = pick_50(rate_sel, rate_q.auto50);

    // R9: the automatic decision only moves on a measured trigger interval
    a_r9_flip_on_trig: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rate_q.auto50) |-> $past(vtrig))
        else $error("rate decision changed without a trigger");

    a_r9_votes_cap: assert property (@(posedge clk) disable iff (!rst_n)
        rate_q.votes <= VLAST)
        else $error("vote count beyond limit");

endmodule

// File: rtl/vcd_std_detect.sv
module vcd_std_detect #(
    parameter int CNT_W  = 10,
    parameter int TOL    = 1,
    parameter int FIELDS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hl_tick,
    input  logic             vtrig,
    input  logic [CNT_W-1:0] gap,
    input  logic [CNT_W-1:0] nom_len,
    input  logic             clear,
    input  logic             force_ns,
    output logic             is_std
);
    localparam int RW = $clog2(FIELDS + 1);
    localparam logic [RW-1:0]    RMAX  = RW'(FIELDS);
    localparam logic [CNT_W-1:0] TOL_C = CNT_W'(TOL);

    typedef struct packed {
        logic          std;
        logic [RW-1:0] run;
    } sdet_t;

    sdet_t sdet_d, sdet_q;
    logic  good, late;
    logic [RW-1:0] run_inc;

    always_comb begin
        good    = (gap >= nom_len - TOL_C) && (gap <= nom_len + TOL_C);
        late    = hl_tick && !vtrig && (gap == nom_len + TOL_C);
        run_inc = (sdet_q.run == RMAX) ? RMAX : sdet_q.run + 1'b1;
        sdet_d  = sdet_q;
        if (clear) begin
            sdet_d = '0;
        end else if (vtrig) begin
            if (good) begin
                sdet_d.run = run_inc;
                sdet_d.std = (run_inc == RMAX);
            end else begin
                sdet_d = '0;
            end
        end else if (late) begin
            sdet_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sdet_q <= '0;
        end else begin
            sdet_q <= sdet_d;
        end
    end

    assign is_std = sdet_q.std && !force_ns;

    // R8: standard state is only entered on a measured trigger
    a_r8_rise_on_trig: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdet_q.std) |-> $past(vtrig))
        else $error("standard entered without trigger");

    a_r8_run_cap: assert property (@(posedge clk) disable iff (!rst_n)
        sdet_q.run <= RMAX)
        else $error("run counter beyond limit");

endmodule

// File: rtl/vcd_field_ctr.sv
module vcd_field_ctr #(
    parameter int CNT_W    = 10,
    parameter int FCNT_MAX = 714
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hl_tick,
    input  logic             vtrig,
    input  logic             std_eff,
    input  logic [CNT_W-1:0] win_lo,
    input  logic [CNT_W-1:0] win_hi,
    input  logic [CNT_W-1:0] fld_len,
    input  logic [CNT_W-1:0] alc_at,
    output logic             vreset,
    output logic             alc_pulse,
    output logic             vdet
);
    localparam logic [CNT_W-1:0] FMAX = CNT_W'(FCNT_MAX);

    typedef struct packed {
        logic [CNT_W-1:0] fcnt;
        logic             vres;
        logic             alc;
        logic             det;
    } fld_t;

    fld_t fld_d, fld_q;
    logic in_win, accept, trig_rst, div_rst, free_rst, rst_ev;

    always_comb begin
        in_win   = (fld_q.fcnt >= win_lo) && (fld_q.fcnt <= win_hi);
        accept   = vtrig && in_win;
        trig_rst = accept && !std_eff;
        div_rst  = hl_tick && std_eff && (fld_q.fcnt >= fld_len - 1'b1);
        free_rst = hl_tick && !std_eff && (fld_q.fcnt >= win_hi);
        rst_ev   = trig_rst || div_rst || free_rst;

        fld_d = fld_q;
        if (rst_ev) begin
            fld_d.fcnt = '0;
        end else if (hl_tick) begin
            fld_d.fcnt = fld_q.fcnt + 1'b1;
        end
        fld_d.vres = rst_ev;
        if (accept) begin
            fld_d.det = 1'b1;
        end else if (free_rst) begin
            fld_d.det = 1'b0;
        end
        fld_d.alc = (fld_d.fcnt >= alc_at) && (fld_d.fcnt <= alc_at + 1'b1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fld_q <= '0;
        end else begin
            fld_q <= fld_d;
        end
    end

    assign vreset    = fld_q.vres;
    assign alc_pulse = fld_q.alc;
    assign vdet      = fld_q.det;

    // R11: reset pulse lasts a single clock
    a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fld_q.vres |=> !fld_q.vres)
        else $error("vreset longer than one clock");

    // R2: a reset not caused by a half-line tick must come from a trigger
    a_r2_reset_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (fld_q.vres && !$past(hl_tick)) |-> $past(vtrig))
        else $error("reset without tick or trigger");

    // R4: the field count never runs past the longest window end
    a_r4_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        fld_q.fcnt <= FMAX)
        else $error("field count overran window end");

    // R5: in standard operation a lone trigger never resets the field
    a_r5_trig_no_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (std_eff && vtrig && !hl_tick) |=> !fld_q.vres)
        else $error("trigger reset a standard field");

endmodule

// File: rtl/vert_countdown.sv
module vert_countdown #(
    parameter int CNT_W       = 10,
    parameter int W60_LO      = 450,
    parameter int W60_HI      = 594,
    parameter int W50_LO      = 576,
    parameter int W50_HI      = 714,
    parameter int LEN60       = 525,
    parameter int LEN50       = 625,
    parameter int ALC60       = 449,
    parameter int ALC50       = 536,
    parameter int STD_TOL     = 1,
    parameter int STD_FIELDS  = 8,
    parameter int RATE_VOTES  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hl_tick,
    input  logic       vtrig,
    input  logic [2:0] mode_sel,
    output logic       vreset,
    output logic       alc_pulse,
    output logic       vdet,
    output logic       is_50hz,
    output logic       is_std
);
    localparam int FCNT_MAX = (W50_HI > W60_HI) ? W50_HI : W60_HI;
    localparam logic [CNT_W-1:0] C60_LO  = CNT_W'(W60_LO);
    localparam logic [CNT_W-1:0] C60_HI  = CNT_W'(W60_HI);
    localparam logic [CNT_W-1:0] C50_LO  = CNT_W'(W50_LO);
    localparam logic [CNT_W-1:0] C50_HI  = CNT_W'(W50_HI);
    localparam logic [CNT_W-1:0] C60_LEN = CNT_W'(LEN60);
    localparam logic [CNT_W-1:0] C50_LEN = CNT_W'(LEN50);
    localparam logic [CNT_W-1:0] C60_ALC = CNT_W'(ALC60);
    localparam logic [CNT_W-1:0] C50_ALC = CNT_W'(ALC50);

    logic [CNT_W-1:0] gap, win_lo, win_hi, fld_len, alc_at;
    logic             is50, flip, std_eff;

    vcd_interval #(.CNT_W(CNT_W)) u_ival (
        .clk     (clk),
        .rst_n   (rst_n),
        .hl_tick (hl_tick),
        .vtrig   (vtrig),
        .gap     (gap)
    );

    vcd_rate_sel #(
        .CNT_W(CNT_W), .W60_LO(W60_LO), .W60_HI(W60_HI),
        .W50_LO(W50_LO), .W50_HI(W50_HI), .VOTES(RATE_VOTES)
    ) u_rate (
        .clk      (clk),
        .rst_n    (rst_n),
        .vtrig    (vtrig),
        .gap      (gap),
        .rate_sel (mode_sel[1:0]),
        .is50     (is50),
        .flip     (flip)
    );

    assign win_lo  = is50 ? C50_LO  : C60_LO;
    assign win_hi  = is50 ? C50_HI  : C60_HI;
    assign fld_len = is50 ? C50_LEN : C60_LEN;
    assign alc_at  = is50 ? C50_ALC : C60_ALC;

    vcd_std_detect #(
        .CNT_W(CNT_W), .TOL(STD_TOL), .FIELDS(STD_FIELDS)
    ) u_std (
        .clk      (clk),
        .rst_n    (rst_n),
        .hl_tick  (hl_tick),
        .vtrig    (vtrig),
        .gap      (gap),
        .nom_len  (fld_len),
        .clear    (flip),
        .force_ns (mode_sel[2]),
        .is_std   (std_eff)
    );

    vcd_field_ctr #(.CNT_W(CNT_W), .FCNT_MAX(FCNT_MAX)) u_fld (
        .clk       (clk),
        .rst_n     (rst_n),
        .hl_tick   (hl_tick),
        .vtrig     (vtrig),
        .std_eff   (std_eff),
        .win_lo    (win_lo),
        .win_hi    (win_hi),
        .fld_len   (fld_len),
        .alc_at    (alc_at),
        .vreset    (vreset),
        .alc_pulse (alc_pulse),
        .vdet      (vdet)
    );

    assign is_50hz = is50;
    assign is_std  = std_eff;

endmodule

// File: tb/vert_countdown_tb.sv
module vert_countdown_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hl_tick = 1'b0;
    logic       vtrig = 1'b0;
    logic [2:0] mode_sel = 3'b000;
    logic       vreset, alc_pulse, vdet, is_50hz, is_std;

    int n_chk = 0;
    int n_bad = 0;
    int nres  = 0;

    always #10 clk = ~clk;

    vert_countdown u_dut (
        .clk(clk), .rst_n(rst_n), .hl_tick(hl_tick), .vtrig(vtrig),
        .mode_sel(mode_sel), .vreset(vreset), .alc_pulse(alc_pulse),
        .vdet(vdet), .is_50hz(is_50hz), .is_std(is_std)
    );

    always @(negedge clk) if (vreset) nres++;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) hl_tick = 1'b1;
            @(negedge clk) hl_tick = 1'b0;
            @(negedge clk);
            @(negedge clk);
        end
    endtask

    task automatic trig();
        @(negedge clk) vtrig = 1'b1;
        @(negedge clk) vtrig = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_reset(input logic [2:0] m);
        @(negedge clk);
        rst_n = 1'b0; hl_tick = 1'b0; vtrig = 1'b0; mode_sel = m;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        do_reset(3'b000);
        chk("R1 vreset", vreset, 0);
        chk("R1 alc_pulse", alc_pulse, 0);
        chk("R1 vdet", vdet, 0);
        chk("R1 is_50hz", is_50hz, 0);
        chk("R1 is_std", is_std, 0);
    endtask

    task automatic t_win60();
        int b;
        do_reset(3'b110);
        b = nres;
        ticks(100); trig();
        chk("R2 early trigger ignored", nres - b, 0);
        chk("R2 vdet after early trigger", vdet, 0);
        ticks(348);
        chk("R10 alc60 before 449", alc_pulse, 0);
        ticks(1);
        chk("R10 alc60 at 449", alc_pulse, 1);
        trig();
        chk("R2 trigger at 449 ignored", nres - b, 0);
        ticks(1);
        chk("R10 alc60 at 450", alc_pulse, 1);
        trig();
        chk("R2 trigger at 450 accepted", nres - b, 1);
        chk("R11 vreset back low", vreset, 0);
        chk("R2 vdet set", vdet, 1);
        ticks(1);
        chk("R10 alc60 low after reset", alc_pulse, 0);
        ticks(593); trig();
        chk("R2 trigger at 594 accepted", nres - b, 2);
        ticks(594);
        chk("R4 no reset at 594", nres - b, 2);
        chk("R4 vdet held", vdet, 1);
        ticks(1);
        chk("R4 free-run reset 60", nres - b, 3);
        chk("R4 vdet cleared 60", vdet, 0);
    endtask

    task automatic t_win50();
        int b;
        do_reset(3'b101);
        b = nres;
        chk("R7 forced 50", is_50hz, 1);
        ticks(535);
        chk("R10 alc50 before 536", alc_pulse, 0);
        ticks(1);
        chk("R10 alc50 at 536", alc_pulse, 1);
        ticks(1);
        chk("R10 alc50 at 537", alc_pulse, 1);
        ticks(1);
        chk("R10 alc50 at 538", alc_pulse, 0);
        ticks(37); trig();
        chk("R3 trigger at 575 ignored", nres - b, 0);
        ticks(1); trig();
        chk("R3 trigger at 576 accepted", nres - b, 1);
        ticks(714); trig();
        chk("R3 trigger at 714 accepted", nres - b, 2);
        ticks(714);
        chk("R4 no reset at 714", nres - b, 2);
        ticks(1);
        chk("R4 free-run reset 50", nres - b, 3);
        chk("R4 vdet cleared 50", vdet, 0);
    endtask

    task automatic t_standard();
        int b;
        do_reset(3'b010);
        ticks(500); trig();
        for (int k = 1; k <= 8; k++) begin
            ticks(525); trig();
            if (k == 7) chk("R8 not standard after 7", is_std, 0);
            if (k == 8) chk("R8 standard after 8", is_std, 1);
        end
        for (int k = 0; k < 2; k++) begin
            b = nres;
            ticks(524);
            chk("R5 no reset before divider", nres - b, 0);
            trig();
            chk("R5 trigger ignored in standard", nres - b, 0);
            chk("R5 vdet while standard", vdet, 1);
            ticks(1);
            chk("R5 divider reset at 525", nres - b, 1);
            chk("R8 standard held", is_std, 1);
        end
        mode_sel = 3'b110;
        @(negedge clk);
        chk("R6 forced non-standard flag", is_std, 0);
        b = nres;
        ticks(524); trig();
        chk("R6 trigger resets when forced", nres - b, 1);
        mode_sel = 3'b010;
        @(negedge clk);
        chk("R6 automatic decision restored", is_std, 1);
        ticks(526);
        chk("R8 held at nominal+1", is_std, 1);
        ticks(1);
        chk("R8 missing trigger clears", is_std, 0);
    endtask

    task automatic t_rate();
        do_reset(3'b000);
        trig();
        for (int k = 1; k <= 4; k++) begin
            ticks(625); trig();
            if (k == 3) chk("R9 still 60 after 3", is_50hz, 0);
            if (k == 4) chk("R9 switched to 50 after 4", is_50hz, 1);
        end
        mode_sel = 3'b010; @(negedge clk);
        chk("R7 sel 10 forces 60", is_50hz, 0);
        mode_sel = 3'b001; @(negedge clk);
        chk("R7 sel 01 forces 50", is_50hz, 1);
        mode_sel = 3'b011; @(negedge clk);
        chk("R7 sel 11 automatic", is_50hz, 1);
        mode_sel = 3'b000; @(negedge clk);
        chk("R7 sel 00 automatic", is_50hz, 1);
        for (int k = 0; k < 3; k++) begin
            ticks(525); trig();
        end
        ticks(625); trig();
        chk("R9 broken run keeps 50", is_50hz, 1);
        for (int k = 1; k <= 4; k++) begin
            ticks(525); trig();
            if (k == 3) chk("R9 still 50 after 3", is_50hz, 1);
            if (k == 4) chk("R9 back to 60 after 4", is_50hz, 0);
        end
    endtask

    initial begin
        #(190000 * 20);
        n_bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset_state();
        t_win60();
        t_win50();
        t_standard();
        t_rate();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule